// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block holds the pending and active state of the 32 external lines of a small vectored interrupt controller. Software pends a line by writing ones to a set-pending register and withdraws it by writing ones to a clear-pending register. Both registers read back the same pending vector. A read-only active register shows which line is being serviced. A status word carries an "interrupt pending" flag in bit 22 and the number of the exception being serviced in its low byte.

Acceptance happens without software action and is visible as register side effects. The control sequencer has two named states. In `ST_THREAD` the core runs thread code. In `ST_HANDLER` exactly one line is active. The transition `ENTER` (`ST_THREAD` to `ST_HANDLER`) fires on the first clock edge at which anything is pending. On that edge the lowest pending line moves from pending to active, a one-cycle `exc_take` pulse is raised, and the exception number (line index plus 16) is reported. The transition `LEAVE` (`ST_HANDLER` to `ST_THREAD`) fires on the edge that samples a one-cycle `exc_return` strobe. It clears the active bit. A line that is still pending is then entered on the following edge.

Register offsets on `wr_addr` and `rd_addr`: 0 is set-pending, 1 is clear-pending, 2 is active and 3 is status. Reads are combinational. Writes take effect on the clock edge that samples `wr_en`.

Top module: `irq_tracker`

## Requirements
- R1: A write to offset 0 marks line n pending for every 1 in bit n of `wr_data`. Zero bits change nothing. The new bit reads back from offset 0 after the write edge.
- R2: A write to offset 1 clears pending line n for every 1 in bit n. Zero bits change nothing. Reads of offset 1 return the same pending vector as offset 0.
- R3: The status word (offset 3) has bit 22 equal to 1 exactly when any line is pending. Bits 7:0 hold the current exception number, which is 0 in thread mode. All other bits are 0. Writes to offsets 2 and 3 change no register.
- R4: In `ST_THREAD` with at least one line pending, the next edge takes transition `ENTER`. The accepted line's pending bit clears, its active bit sets, `handler_mode` becomes 1 and `exc_take` is 1 for exactly that one cycle.
- R5: At most one active bit is set at any time. `handler_mode` is 1 exactly when one is set.
- R6: `exc_num` equals the accepted line index plus 16, so line 2 reports 18. It holds that value for as long as the handler runs.
- R7: In `ST_HANDLER`, a 1 on `exc_return` at an edge takes transition `LEAVE`. That edge clears the active register, sets `handler_mode` and `exc_num` to 0. In `ST_THREAD`, `exc_return` has no effect.
- R8: When several lines are pending together, the lowest index is accepted first.
- R9: No line is accepted while one is active. Pends made during a handler accumulate.
- R10: A line still pending after `LEAVE` is entered on the very next edge.
- R11: When a write coincides with an `ENTER` edge, the new pending vector is ((old & ~accepted) | set) & ~clear. Setting the accepted line again leaves it pending.
- R12: A synchronous reset on `rst` clears all pending and active bits, `exc_num` and `exc_take`, and leaves the block in `ST_THREAD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write offset (0 set-pending, 1 clear-pending, 2 active, 3 status) |
| wr_data | input | 32 | Write data, one bit per line |
| rd_addr | input | 2 | Read offset, same encoding as `wr_addr` |
| rd_data | output | 32 | Combinational read data |
| exc_return | input | 1 | One-cycle exception-return strobe |
| exc_take | output | 1 | One-cycle pulse after an `ENTER` edge |
| exc_num | output | 8 | Current exception number, 0 in thread mode |
| handler_mode | output | 1 | 1 in `ST_HANDLER`, 0 in `ST_THREAD` |

## Verification
The assertions assume that `exc_return` is a single-cycle strobe, issued only after the handler has seen `exc_take`. They also assume that `rst` is held for at least one edge before checking begins. The stimulus drives every input a fixed delay after the rising edge and raises `exc_return` for exactly one cycle. It also pulses `exc_return` in thread mode to confirm it is ignored. Writes to the read-only offsets and a write that lands on an `ENTER` edge are placed deliberately. This lets the comparison against the behavioural model cover the ordering rule of R11.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

    typedef enum logic [0:0] {
        ST_THREAD  = 1'b0,
        ST_HANDLER = 1'b1
    } run_state_t;

    typedef enum logic [1:0] {
        RA_SETPEND = 2'd0,
        RA_CLRPEND = 2'd1,
        RA_ACTIVE  = 2'd2,
        RA_STATUS  = 2'd3
    } reg_addr_t;

    localparam int PEND_FLAG_BIT = 22;

endpackage

// File: rtl/irqt_lowest_sel.sv
module irqt_lowest_sel #(
    parameter int NUM_IRQ = 32,
    localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0] req,
    output logic [NUM_IRQ-1:0] grant,
    output logic [IDX_W-1:0]   grant_idx,
    output logic               any_req
);

    logic [NUM_IRQ:0] below;

    assign below[0] = 1'b0;

    generate
        for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chain
            assign grant[g]   = req[g] & ~below[g];
            assign below[g+1] = below[g] | req[g];
        end
    endgenerate

    assign any_req = below[NUM_IRQ];

    always_comb begin
        grant_idx = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqt_pend_bank.sv
module irqt_pend_bank #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] set_mask,
    input  logic [NUM_IRQ-1:0] clr_mask,
    input  logic [NUM_IRQ-1:0] taken_mask,
    output logic [NUM_IRQ-1:0] pend
);

    logic [NUM_IRQ-1:0] pend_next;

    always_comb begin
        pend_next = ((pend & ~taken_mask) | set_mask) & ~clr_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            pend <= pend_next;
        end
    end

endmodule

// File: rtl/irqt_seq.sv
module irqt_seq
    import irqt_pkg::*;
#(
    parameter int NUM_IRQ    = 32,
    parameter int EXC_W      = 8,
    parameter int EXC_OFFSET = 16,
    localparam int IDX_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               any_pend,
    input  logic [NUM_IRQ-1:0] grant,
    input  logic [IDX_W-1:0]   grant_idx,
    input  logic               exc_return,
    output logic [NUM_IRQ-1:0] taken_mask,
    output logic [NUM_IRQ-1:0] active,
    output logic [EXC_W-1:0]   exc_num,
    output logic               exc_take,
    output logic               handler_mode
);

    run_state_t state_q, state_d;
    logic       do_enter;
    logic       do_leave;

    // transition decode
    always_comb begin
        state_d  = state_q;
        do_enter = 1'b0;
        do_leave = 1'b0;
        unique case (state_q)
            ST_THREAD: begin
                if (any_pend) begin
                    state_d  = ST_HANDLER;
                    do_enter = 1'b1;
                end
            end
            ST_HANDLER: begin
                if (exc_return) begin
                    state_d  = ST_THREAD;
                    do_leave = 1'b1;
                end
            end
            default: state_d = ST_THREAD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_THREAD;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= '0;
            exc_num  <= '0;
            exc_take <= 1'b0;
        end else begin
            exc_take <= do_enter;
            if (do_enter) begin
                active  <= grant;
                exc_num <= EXC_W'(grant_idx) + EXC_W'(EXC_OFFSET);
            end else if (do_leave) begin
                active  <= '0;
                exc_num <= '0;
            end
        end
    end

    assign taken_mask   = do_enter ? grant : '0;
    assign handler_mode = (state_q == ST_HANDLER);

endmodule

// File: rtl/irq_tracker.sv
module irq_tracker
    import irqt_pkg::*;
#(
    parameter int NUM_IRQ    = 32,
    parameter int DATA_W     = 32,
    parameter int EXC_W      = 8,
    parameter int EXC_OFFSET = 16,
    localparam int IDX_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              exc_return,
    output logic              exc_take,
    output logic [EXC_W-1:0]  exc_num,
    output logic              handler_mode
);

    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] active_q;
    logic [NUM_IRQ-1:0] set_mask;
    logic [NUM_IRQ-1:0] clr_mask;
    logic [NUM_IRQ-1:0] taken_mask;
    logic [NUM_IRQ-1:0] grant;
    logic [IDX_W-1:0]   grant_idx;
    logic               any_pend;
    logic [DATA_W-1:0]  status_word;

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (wr_en && (wr_addr == RA_SETPEND)) begin
            set_mask = wr_data[NUM_IRQ-1:0];
        end
        if (wr_en && (wr_addr == RA_CLRPEND)) begin
            clr_mask = wr_data[NUM_IRQ-1:0];
        end
    end

    irqt_pend_bank #(.NUM_IRQ(NUM_IRQ)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .set_mask   (set_mask),
        .clr_mask   (clr_mask),
        .taken_mask (taken_mask),
        .pend       (pend_q)
    );

    irqt_lowest_sel #(.NUM_IRQ(NUM_IRQ)) u_sel (
        .req       (pend_q),
        .grant     (grant),
        .grant_idx (grant_idx),
        .any_req   (any_pend)
    );

    irqt_seq #(
        .NUM_IRQ    (NUM_IRQ),
        .EXC_W      (EXC_W),
        .EXC_OFFSET (EXC_OFFSET)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .any_pend     (any_pend),
        .grant        (grant),
        .grant_idx    (grant_idx),
        .exc_return   (exc_return),
        .taken_mask   (taken_mask),
        .active       (active_q),
        .exc_num      (exc_num),
        .exc_take     (exc_take),
        .handler_mode (handler_mode)
    );

    always_comb begin
        status_word                = '0;
        status_word[EXC_W-1:0]     = exc_num;
        status_word[PEND_FLAG_BIT] = any_pend;
    end

    always_comb begin
        unique case (rd_addr)
            RA_SETPEND: rd_data = DATA_W'(pend_q);
            RA_CLRPEND: rd_data = DATA_W'(pend_q);
            RA_ACTIVE:  rd_data = DATA_W'(active_q);
            RA_STATUS:  rd_data = status_word;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irqt_checker.sv
module irqt_checker #(
    parameter int NUM_IRQ    = 32,
    parameter int EXC_W      = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_IRQ-1:0] pend,
    input logic [NUM_IRQ-1:0] active,
    input logic               handler_mode,
    input logic               exc_take,
    input logic [EXC_W-1:0]   exc_num,
    input logic               exc_return
);

    assert_active_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(active));

    assert_mode_tracks_active_R5: assert property (@(posedge clk) disable iff (rst)
        handler_mode == (active != '0));

    assert_take_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> !exc_take);

    assert_lowest_first_R8: assert property (@(posedge clk) disable iff (rst)
        exc_take |-> ((($past(pend) & (active - NUM_IRQ'(1))) == '0) &&
                      (($past(pend) & active) != '0)));

    assert_leave_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (handler_mode && exc_return) |=> (!handler_mode && (active == '0)));

    assert_no_nesting_R9: assert property (@(posedge clk) disable iff (rst)
        (handler_mode && !exc_return) |=> (!exc_take && $stable(active) && $stable(exc_num)));

    assert_thread_num_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !handler_mode |-> (exc_num == '0));

endmodule

bind irq_tracker irqt_checker #(
    .NUM_IRQ (NUM_IRQ),
    .EXC_W   (EXC_W)
) u_irqt_checker (
    .clk          (clk),
    .rst          (rst),
    .pend         (pend_q),
    .active       (active_q),
    .handler_mode (handler_mode),
    .exc_take     (exc_take),
    .exc_num      (exc_num),
    .exc_return   (exc_return)
);

// File: tb/test_irq_tracker.sv
module test_irq_tracker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic [1:0]  rd_addr;
    logic [31:0] rd_data;
    logic        exc_return;
    logic        exc_take;
    logic [7:0]  exc_num;
    logic        handler_mode;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    logic [31:0] m_pend, m_act;
    logic        m_hand, m_take;
    logic [7:0]  m_num;
    logic [31:0] snap [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_tracker i_irq_tracker (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .exc_return   (exc_return),
        .exc_take     (exc_take),
        .exc_num      (exc_num),
        .handler_mode (handler_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        logic [31:0] acc;
        logic [31:0] p;
        acc = '0;
        if (rst) begin
            m_pend = '0; m_act = '0; m_hand = 1'b0; m_take = 1'b0; m_num = '0;
        end else begin
            m_take = 1'b0;
            if (!m_hand && (m_pend != 0)) begin
                for (int i = 31; i >= 0; i--) begin
                    if (m_pend[i]) acc = 32'd1 << i;
                end
                for (int i = 0; i < 32; i++) begin
                    if (acc[i]) m_num = 8'(i + 16);
                end
                m_act = acc; m_hand = 1'b1; m_take = 1'b1;
            end else if (m_hand && exc_return) begin
                m_act = '0; m_hand = 1'b0; m_num = '0;
            end
            p = m_pend & ~acc;
            if (wr_en && wr_addr == 2'd0) p = p | wr_data;
            if (wr_en && wr_addr == 2'd1) p = p & ~wr_data;
            m_pend = p;
        end
    end

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R4 handler_mode", {31'd0, handler_mode}, {31'd0, m_hand});
            chk("R4 exc_take", {31'd0, exc_take}, {31'd0, m_take});
            chk("R6 exc_num", {24'd0, exc_num}, {24'd0, m_num});
        end
        for (int a = 0; a < 4; a++) begin
            rd_addr = a[1:0];
            #1;
            snap[a] = rd_data;
            if (!rst) begin
                case (a)
                    0: chk("R1 setpend view", rd_data, m_pend);
                    1: chk("R2 clrpend view", rd_data, m_pend);
                    2: chk("R5 active view", rd_data, m_act);
                    default: chk("R3 status view", rd_data,
                                 {9'd0, (m_pend != 0), 14'd0, m_num});
                endcase
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic put_wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [31:0] d);
        step();
        put_wr(a, d);
    endtask

    task automatic ret_pulse();
        step();
        exc_return = 1'b1;
        step();
        exc_return = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; exc_return = 1'b0; rd_addr = '0;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R12 reset status", snap[3], 32'd0);
        chk("R12 reset mode", {31'd0, handler_mode}, 32'd0);

        // pend line 2
        do_wr(2'd0, 32'd4);
        step();
        chk("R1 pend line 2", snap[0], 32'd4);
        chk("R2 clr view mirrors", snap[1], 32'd4);
        chk("R3 pend flag set", snap[3], 32'h0040_0000);
        chk("R4 entered", {31'd0, handler_mode}, 32'd1);
        chk("R4 take pulse", {31'd0, exc_take}, 32'd1);
        chk("R6 line 2 number", {24'd0, exc_num}, 32'd18);
        step();
        chk("R4 pend cleared", snap[0], 32'd0);
        chk("R4 active set", snap[2], 32'd4);
        chk("R3 flag cleared", snap[3], 32'd18);
        chk("R4 take ended", {31'd0, exc_take}, 32'd0);

        // pends during handler, clears, read-only writes
        do_wr(2'd0, 32'h30);
        do_wr(2'd1, 32'h20);
        do_wr(2'd2, 32'hFFFF_FFFF);
        do_wr(2'd3, 32'hFFFF_FFFF);
        step();
        step();
        chk("R9 pends accumulate", snap[0], 32'h10);
        chk("R3 active unwritable", snap[2], 32'd4);
        chk("R9 still handler", {24'd0, exc_num}, 32'd18);

        ret_pulse();
        chk("R7 leave", {31'd0, handler_mode}, 32'd0);
        chk("R7 num zero", {24'd0, exc_num}, 32'd0);
        step();
        chk("R10 reentry", {24'd0, exc_num}, 32'd20);
        chk("R10 take", {31'd0, exc_take}, 32'd1);

        ret_pulse();
        do_wr(2'd0, 32'h8000_0100);
        step();
        chk("R8 lowest first", {24'd0, exc_num}, 32'd24);
        ret_pulse();
        step();
        chk("R8 then line 31", {24'd0, exc_num}, 32'd47);
        ret_pulse();
        step();

        // exc_return in thread mode
        ret_pulse();
        step();
        chk("R7 ignored in thread", {31'd0, handler_mode}, 32'd0);
        chk("R7 active stays zero", snap[2], 32'd0);

        // write coinciding with an entry edge
        do_wr(2'd0, 32'd8);
        put_wr(2'd0, 32'd8);
        step();
        chk("R11 repended", snap[0], 32'd8);
        chk("R11 active", snap[2], 32'd8);
        chk("R6 line 3 number", {24'd0, exc_num}, 32'd19);
        ret_pulse();
        step();
        chk("R11 taken again", {31'd0, exc_take}, 32'd1);

        do_wr(2'd0, 32'h40);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R12 reset in handler", {31'd0, handler_mode}, 32'd0);
        step();
        step();
        chk("R12 pend cleared", snap[0], 32'd0);
        chk("R12 active cleared", snap[2], 32'd0);

        repeat (3) step();
        finish_run();
    end

endmodule